// File: doc/BRIEF.md
# Constant-Latency Cosine Power Unit

This unit raises a fraction to an integer power in a fixed number of cycles. A shading pipeline uses it to form the specular term, a cosine raised to a gloss exponent. The number of cycles does not depend on the exponent. The input fraction is a 9-bit code read as `in_frac / 512`. The exponent `in_gloss` is a 4-bit unsigned integer from 0 to 15.

The unit works through logarithms. A 512-entry table gives the negative base-2 logarithm of the input as an unsigned fixed-point value with 9 fraction bits. That value is multiplied by the exponent, and the product is split into an integer part and a fraction part. A second 512-entry table turns the fraction part into a mantissa between 256 and 512. The mantissa is then shifted right by the integer part. Each evaluation therefore takes one multiply, two table reads and one shift.

Both tables are computed at elaboration by integer-only constant functions. The pipeline takes a new operand every cycle and has no backpressure.

Top module: `cpow_unit`

## Requirements
- R1: `out_valid` is exactly `in_valid` delayed by 4 clock cycles. This holds for every exponent, including back-to-back inputs. While reset is held, `out_valid` and `out_frac` are 0.
- R2: An input code of 0 yields an output of 0 for every exponent, including 0.
- R3: An input code of 511 is treated as exactly 1.0 and yields 511 for every exponent.
- R4: An exponent of 0 with a nonzero input yields 511, the saturated value of 1.0.
- R5: For inputs from 1 to 510 and exponents from 1 to 15, let e = (in_frac/512)^in_gloss × 512. The output lies within 2 + e/32 of e.
- R6: When the integer part of in_gloss × (−log2 x) is 9 or more, the output is forced to 0. This covers every exponent ≥ 1 when in_frac = 1, and every case where in_gloss × (−log2 x) ≥ 9.1.
- R7: For an input code 2^k with k from 0 to 8 and an exponent n ≥ 1, the output is exactly 512 >> (n × (9 − k)). Any shift of 9 or more gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_frac | input | 9 | Base fraction, code/512; code 511 means 1.0 |
| in_gloss | input | 4 | Integer exponent, 0 to 15 |
| out_valid | output | 1 | Result present, 4 cycles after the operand |
| out_frac | output | 9 | Result fraction, code/512, saturated at 511 |

## Verification
Several properties are checked on every cycle. These are:
- the fixed four-cycle relation between `in_valid` and `out_valid`;
- the forced results for a zero input, a full-scale input and a zero exponent;
- the rule that a shift amount of nine or more clears the result.

Only the bench's scenarios can show how close the output comes to the true power, since that depends on the contents of both tables. Exact power-of-two inputs check the table contents bit for bit. A bounded error is checked against a real-valued reference under random operands with mixed idle gaps.

// File: rtl/cpow_pkg.sv
package cpow_pkg;

    localparam int FRAC_W  = 9;
    localparam int GLOSS_W = 4;
    localparam int LOG_FB  = 9;
    localparam int REF_FB  = 16;
    localparam int LUT_N   = 1 << FRAC_W;
    localparam int ANT_N   = 1 << LOG_FB;
    localparam int LOG_W   = $clog2((FRAC_W << LOG_FB) + 1);
    localparam int PROD_W  = LOG_W + GLOSS_W;
    localparam int INT_W   = PROD_W - LOG_FB;
    localparam int ANT_W   = FRAC_W + 1;
    localparam int LAT     = 4;

    localparam logic [FRAC_W-1:0] FULL_CODE = '1;

    typedef logic [LUT_N-1:0][LOG_W-1:0] log_lut_t;
    typedef logic [ANT_N-1:0][ANT_W-1:0] ant_lut_t;

    typedef struct packed {
        logic valid;
        logic zero;
        logic full;
    } tag_t;

    typedef struct packed {
        tag_t                 tag;
        logic [LOG_W-1:0]     nlog;
        logic [GLOSS_W-1:0]   gloss;
    } s1_t;

    typedef struct packed {
        tag_t                 tag;
        logic [PROD_W-1:0]    prod;
    } s2_t;

    typedef struct packed {
        tag_t                 tag;
        logic [ANT_W-1:0]     mant;
        logic [INT_W-1:0]     shamt;
    } s3_t;

    // -log2(code / 2^FRAC_W) in unsigned fixed point with fb fraction bits,
    // fraction bits produced by repeated squaring of the normalised mantissa.
    function automatic longint neg_log2_q(input int code, input int fb);
        int              p;
        longint unsigned m;
        longint          frac;
        p = 0;
        for (int b = 0; b <= FRAC_W; b++) begin
            if (((code >> b) & 1) != 0) p = b;
        end
        m = longint'(code) << (30 - p);
        frac = 0;
        for (int k = 0; k < fb; k++) begin
            m = (m * m) >> 30;
            frac = frac * 2;
            if (m >= (64'd1 << 31)) begin
                frac = frac + 1;
                m = m >> 1;
            end
        end
        return (longint'(FRAC_W - p) << fb) - frac;
    endfunction

    function automatic log_lut_t build_log_lut();
        log_lut_t t;
        longint   v;
        t[0] = LOG_W'(FRAC_W << LOG_FB);
        for (int i = 1; i < LUT_N; i++) begin
            v = neg_log2_q(i, LOG_FB + 1);
            t[i] = LOG_W'((v + 1) >>> 1);
        end
        return t;
    endfunction

    // Mantissa 2^(-f/ANT_N) * LUT_N, taken as the smallest code whose
    // negative log does not exceed the target (monotone sweep).
    function automatic ant_lut_t build_ant_lut();
        ant_lut_t t;
        int       a;
        longint   tgt;
        a = LUT_N;
        for (int f = 0; f < ANT_N; f++) begin
            tgt = longint'(f) << (REF_FB - LOG_FB);
            while (a > LUT_N / 2 && neg_log2_q(a - 1, REF_FB) <= tgt) a--;
            t[f] = ANT_W'(a);
        end
        return t;
    endfunction

endpackage

// File: rtl/cpow_log_stage.sv
module cpow_log_stage
    import cpow_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [FRAC_W-1:0]  in_frac,
    input  logic [GLOSS_W-1:0] in_gloss,
    output s1_t                s1_q
);

    localparam log_lut_t LOG_LUT = build_log_lut();

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.tag.valid <= in_valid;
            s1_q.tag.zero  <= (in_frac == '0);
            s1_q.tag.full  <= (in_frac == FULL_CODE);
            s1_q.nlog      <= LOG_LUT[in_frac];
            s1_q.gloss     <= in_gloss;
        end
    end

endmodule

// File: rtl/cpow_mul_stage.sv
module cpow_mul_stage
    import cpow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s1_t  s1_i,
    output s2_t  s2_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.tag  <= s1_i.tag;
            s2_q.prod <= PROD_W'(s1_i.nlog) * PROD_W'(s1_i.gloss);
        end
    end

endmodule

// File: rtl/cpow_exp_stage.sv
module cpow_exp_stage
    import cpow_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s2_t  s2_i,
    output s3_t  s3_q
);

    localparam ant_lut_t ANT_LUT = build_ant_lut();

    always_ff @(posedge clk) begin
        if (rst) begin
            s3_q <= '0;
        end else begin
            s3_q.tag   <= s2_i.tag;
            s3_q.mant  <= ANT_LUT[s2_i.prod[LOG_FB-1:0]];
            s3_q.shamt <= s2_i.prod[PROD_W-1:LOG_FB];
        end
    end

endmodule

// File: rtl/cpow_shift_stage.sv
module cpow_shift_stage
    import cpow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  s3_t               s3_i,
    output logic              out_valid,
    output logic [FRAC_W-1:0] out_frac
);

    localparam logic [ANT_W-1:0] SAT   = ANT_W'(LUT_N - 1);
    localparam logic [INT_W-1:0] LIMIT = INT_W'(FRAC_W);

    logic [ANT_W-1:0]  shifted;
    logic [FRAC_W-1:0] res;

    always_comb begin
        shifted = s3_i.mant >> s3_i.shamt;
        if (s3_i.tag.zero)             res = '0;
        else if (s3_i.tag.full)        res = FULL_CODE;
        else if (s3_i.shamt >= LIMIT)  res = '0;
        else if (shifted > SAT)        res = FULL_CODE;
        else                           res = shifted[FRAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_frac  <= '0;
        end else begin
            out_valid <= s3_i.tag.valid;
            out_frac  <= res;
        end
    end

    assert_deep_shift_R6: assert property (@(posedge clk) disable iff (rst)
        (s3_i.tag.valid && !s3_i.tag.zero && !s3_i.tag.full && s3_i.shamt >= LIMIT)
        |=> (out_frac == '0));

endmodule

// File: rtl/cpow_unit.sv
module cpow_unit
    import cpow_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [FRAC_W-1:0]  in_frac,
    input  logic [GLOSS_W-1:0] in_gloss,
    output logic               out_valid,
    output logic [FRAC_W-1:0]  out_frac
);

    s1_t s1;
    s2_t s2;
    s3_t s3;

    cpow_log_stage u_log (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_frac  (in_frac),
        .in_gloss (in_gloss),
        .s1_q     (s1)
    );

    cpow_mul_stage u_mul (
        .clk  (clk),
        .rst  (rst),
        .s1_i (s1),
        .s2_q (s2)
    );

    cpow_exp_stage u_exp (
        .clk  (clk),
        .rst  (rst),
        .s2_i (s2),
        .s3_q (s3)
    );

    cpow_shift_stage u_shift (
        .clk       (clk),
        .rst       (rst),
        .s3_i      (s3),
        .out_valid (out_valid),
        .out_frac  (out_frac)
    );

    // Cycles since reset, so that 4-deep history is only consulted once it exists.
    localparam logic [2:0] WARM = 3'(LAT);
    logic [2:0] warm_q;

    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != WARM) warm_q <= warm_q + 3'd1;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WARM) |-> (out_valid == $past(in_valid, 4)));

    assert_zero_in_R2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WARM && out_valid && $past(in_frac, 4) == '0)
        |-> (out_frac == '0));

    assert_full_in_R3: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WARM && out_valid && $past(in_frac, 4) == FULL_CODE)
        |-> (out_frac == FULL_CODE));

    assert_gloss_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (warm_q == WARM && out_valid && $past(in_gloss, 4) == '0 && $past(in_frac, 4) != '0)
        |-> (out_frac == FULL_CODE));

endmodule

// File: tb/cpow_unit_tb.sv
`timescale 1ns/1ps
module cpow_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [8:0] in_frac = '0;
    logic [3:0] in_gloss = '0;
    logic       out_valid;
    logic [8:0] out_frac;

    always #2.5 clk = ~clk;

    cpow_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_frac   (in_frac),
        .in_gloss  (in_gloss),
        .out_valid (out_valid),
        .out_frac  (out_frac)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    logic [3:0] hist = '0;

    int    exp_lo [4096];
    int    exp_hi [4096];
    string exp_rq [4096];
    int    wr_ix = 0;
    int    rd_ix = 0;

    function automatic int pow2_index(input int x);
        int k = -1;
        for (int b = 0; b < 9; b++) if (x == (1 << b)) k = b;
        return k;
    endfunction

    task automatic push_expect(input int x, input int n);
        int    lo, hi, k, sh;
        real   e, tol, nl;
        string rq;
        k = pow2_index(x);
        if (x == 0) begin
            lo = 0; hi = 0; rq = "R2";
        end else if (x == 511) begin
            lo = 511; hi = 511; rq = "R3";
        end else if (n == 0) begin
            lo = 511; hi = 511; rq = "R4";
        end else if (k >= 0) begin
            sh = n * (9 - k);
            lo = (sh >= 9) ? 0 : (512 >> sh);
            hi = lo; rq = "R7";
        end else begin
            nl = -$ln(real'(x) / 512.0) / $ln(2.0);
            if (real'(n) * nl >= 9.1) begin
                lo = 0; hi = 0; rq = "R6";
            end else begin
                e   = $pow(real'(x) / 512.0, real'(n)) * 512.0;
                tol = 2.0 + e / 32.0;
                lo  = (e - tol < 0.0) ? 0 : $rtoi(e - tol);
                hi  = $rtoi(e + tol) + 1;
                if (hi > 511) hi = 511;
                rq  = "R5";
            end
        end
        exp_lo[wr_ix % 4096] = lo;
        exp_hi[wr_ix % 4096] = hi;
        exp_rq[wr_ix % 4096] = rq;
        wr_ix++;
    endtask

    task automatic check_outputs();
        int lo, hi;
        checks++;
        if (out_valid !== hist[3]) begin
            failures++;
            $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, hist[3]);
        end
        if (out_valid === 1'b1 && hist[3] && rd_ix < wr_ix) begin
            lo = exp_lo[rd_ix % 4096];
            hi = exp_hi[rd_ix % 4096];
            checks++;
            if (int'(out_frac) < lo || int'(out_frac) > hi) begin
                failures++;
                $display("FAIL %s out_frac actual=%0d expected=[%0d,%0d]",
                         exp_rq[rd_ix % 4096], out_frac, lo, hi);
            end
            rd_ix++;
        end
    endtask

    task automatic step(input logic v, input int x, input int n);
        @(negedge clk);
        check_outputs();
        hist = {hist[2:0], v};
        in_valid = v;
        in_frac  = 9'(x);
        in_gloss = 4'(n);
        if (v) push_expect(x, n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681357));
        // R1: reset state
        repeat (5) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_frac !== 9'd0) begin
                failures++;
                $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_valid, out_frac);
            end
        end
        @(negedge clk);
        rst = 1'b0;

        // Directed corners
        step(1, 0, 5);      // R2
        step(1, 0, 0);      // R2
        step(1, 511, 1);    // R3
        step(1, 511, 15);   // R3
        step(1, 511, 0);    // R3
        step(1, 300, 0);    // R4
        step(1, 1, 0);      // R4
        step(1, 256, 1);    // R7 -> 256
        step(1, 256, 3);    // R7 -> 64
        step(1, 128, 2);    // R7 -> 32
        step(1, 256, 8);    // R7 -> 2
        step(1, 256, 9);    // R7 / R6 -> 0
        step(1, 16, 1);     // R7 -> 16
        step(1, 16, 2);     // R6 -> 0
        step(1, 1, 1);      // R6 -> 0
        step(1, 1, 15);     // R6 -> 0
        step(1, 2, 9);      // R6 -> 0
        step(1, 400, 1);    // R5
        step(1, 500, 15);   // R5
        step(1, 510, 7);    // R5
        step(0, 0, 0);
        step(0, 0, 0);

        // R1/R5: back-to-back random operands
        for (int i = 0; i < 400; i++)
            step(1, int'($urandom_range(511, 0)), int'($urandom_range(15, 0)));

        // R1/R5: sparse random operands
        for (int i = 0; i < 400; i++)
            step(($urandom_range(1, 0) == 1), int'($urandom_range(511, 0)),
                 int'($urandom_range(15, 0)));

        // Drain and confirm idle (R1)
        for (int i = 0; i < 8; i++) step(0, 0, 0);

        checks++;
        if (rd_ix != wr_ix) begin
            failures++;
            $display("FAIL R1 results actual=%0d expected=%0d", rd_ix, wr_ix);
        end
        finish_run();
    end

endmodule